// File: doc/BRIEF.md
# iSLIP Crossbar Scheduler

This block decides, once per clock, which inputs of an 8-by-8 input-buffered crossbar may send and to which output. Every input offers a request vector that lists the outputs it holds traffic for. One scheduling pass has three phases. In the request phase every output gathers the inputs that want it. In the grant phase a round-robin arbiter per output picks one of those inputs. In the accept phase a round-robin arbiter per input picks one of the outputs that granted it. The result is a matching in which no input and no output appears twice.

The arbiter pointers move only when a grant is accepted. Each moves to the position one past the partner it was matched with. Under steady load this desynchronises the arbiters, so the outputs stop all granting the same input. Each input learns the outcome through a transmit flag and a one-hot match row. Each output learns it through a valid flag and the index of the input to connect, and that index drives the crossbar select.

Top module: `islip_sched`

## Requirements
- R1: While rst_ni is low, every output is 0. All grant and accept pointers return to 0, so the first pass after reset favours index 0 in every arbiter.
- R2: A match pairs each input with at most one output and each output with at most one input. It is set only where the request vector seen on the previous clock asked for that pair.
- R3: Each output grants the requesting input found first when scanning cyclically from its grant pointer (the pointer index included).
- R4: Each input accepts the granting output found first when scanning cyclically from its accept pointer (the pointer index included).
- R5: When an output's grant is accepted, its grant pointer becomes the matched input index plus one, modulo 8.
- R6: When an input accepts, its accept pointer becomes the accepted output index plus one, modulo 8.
- R7: An output whose grant is not accepted, or that had no requests, keeps its grant pointer. An input that accepts nothing keeps its accept pointer.
- R8: Outputs are registered. A request vector presented before a rising edge yields its matching right after that edge, in a single iteration. An all-zero request gives an empty matching.
- R9: xmit_o[i] is 1 exactly when input i is matched. out_vld_o[j] is 1 exactly when output j is matched. Then sel_o[3j+2:3j] holds the matched input index.
- R10: Bit 8i+j of req_i means input i has traffic for output j. Bit 8i+j of match_o means input i is connected to output j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 64 | Request matrix, bit 8i+j = input i wants output j |
| match_o | output | 64 | Matching, bit 8i+j = input i connected to output j |
| xmit_o | output | 8 | Per input: transmit this cycle |
| sel_o | output | 24 | Per output: 3-bit index of the selected input |
| out_vld_o | output | 8 | Per output: a connection exists |

## Verification
A run of full request matrices starting from reset shows whether the pointers desynchronise. The matching has to grow from one pair to two, three and four diagonal pairs, and that happens only if pointers move one past the accepted partner. An all-zero step placed inside that run shows that idle cycles leave the pointers alone. A sparse pattern in which one input receives two grants but accepts only one then separates "move on acceptance" from "move on grant". A request on the last input and output then checks the wrap of the pointer modulo 8.

// File: rtl/islip_pkg.sv
package islip_pkg;
  localparam int unsigned ISLIP_PORTS = 8;

  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1) % n;
  endfunction
endpackage

// File: rtl/islip_rr_arb.sv
module islip_rr_arb #(
  parameter int unsigned N     = 8,
  parameter int unsigned PTR_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [N-1:0]     gnt_o,
  output logic [PTR_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    vld_o = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      int p;
      p = (int'(ptr_i) + k) % int'(N);
      if (!vld_o && req_i[p]) begin
        vld_o    = 1'b1;
        gnt_o[p] = 1'b1;
        idx_o    = PTR_W'(p);
      end
    end
  end
endmodule

// File: rtl/islip_grant_stage.sv
module islip_grant_stage #(
  parameter int unsigned N     = 8,
  parameter int unsigned PTR_W = $clog2(N)
) (
  input  logic [N*N-1:0]     req_i,
  input  logic [N*PTR_W-1:0] gptr_i,
  output logic [N*N-1:0]     gnt_o   // bit i*N+j: output j grants input i
);
  for (genvar j = 0; j < int'(N); j++) begin : g_out
    logic [N-1:0]     col;
    logic [N-1:0]     pick;
    logic [PTR_W-1:0] idx_unused;
    logic             vld_unused;
    for (genvar i = 0; i < int'(N); i++) begin : g_in
      assign col[i]         = req_i[i*N+j];
      assign gnt_o[i*N+j]   = pick[i];
    end
    islip_rr_arb #(.N(N), .PTR_W(PTR_W)) u_arb (
      .req_i (col),
      .ptr_i (gptr_i[j*PTR_W +: PTR_W]),
      .gnt_o (pick),
      .idx_o (idx_unused),
      .vld_o (vld_unused)
    );
  end
endmodule

// File: rtl/islip_accept_stage.sv
module islip_accept_stage #(
  parameter int unsigned N     = 8,
  parameter int unsigned PTR_W = $clog2(N)
) (
  input  logic [N*N-1:0]     gnt_i,
  input  logic [N*PTR_W-1:0] aptr_i,
  output logic [N*N-1:0]     acc_o,
  output logic [N*PTR_W-1:0] acc_idx_o,
  output logic [N-1:0]       acc_vld_o
);
  for (genvar i = 0; i < int'(N); i++) begin : g_in
    islip_rr_arb #(.N(N), .PTR_W(PTR_W)) u_arb (
      .req_i (gnt_i[i*N +: N]),
      .ptr_i (aptr_i[i*PTR_W +: PTR_W]),
      .gnt_o (acc_o[i*N +: N]),
      .idx_o (acc_idx_o[i*PTR_W +: PTR_W]),
      .vld_o (acc_vld_o[i])
    );
  end
endmodule

// File: rtl/islip_sched.sv
module islip_sched
  import islip_pkg::*;
#(
  parameter int unsigned N_PORTS = ISLIP_PORTS,
  parameter int unsigned PTR_W   = $clog2(N_PORTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_PORTS*N_PORTS-1:0] req_i,
  output logic [N_PORTS*N_PORTS-1:0] match_o,
  output logic [N_PORTS-1:0]         xmit_o,
  output logic [N_PORTS*PTR_W-1:0]   sel_o,
  output logic [N_PORTS-1:0]         out_vld_o
);
  localparam int unsigned NN = N_PORTS * N_PORTS;

  logic [N_PORTS*PTR_W-1:0] gptr_q, gptr_d;
  logic [N_PORTS*PTR_W-1:0] aptr_q, aptr_d;
  logic [NN-1:0]            gnt;
  logic [NN-1:0]            acc;
  logic [N_PORTS*PTR_W-1:0] acc_idx;
  logic [N_PORTS-1:0]       acc_vld;
  logic [N_PORTS*PTR_W-1:0] out_sel_d;
  logic [N_PORTS-1:0]       out_vld_d;

  islip_grant_stage #(.N(N_PORTS), .PTR_W(PTR_W)) u_grant (
    .req_i  (req_i),
    .gptr_i (gptr_q),
    .gnt_o  (gnt)
  );

  islip_accept_stage #(.N(N_PORTS), .PTR_W(PTR_W)) u_accept (
    .gnt_i     (gnt),
    .aptr_i    (aptr_q),
    .acc_o     (acc),
    .acc_idx_o (acc_idx),
    .acc_vld_o (acc_vld)
  );

  // Per-output view of the accepted matching
  always_comb begin
    out_sel_d = '0;
    out_vld_d = '0;
    for (int j = 0; j < int'(N_PORTS); j++) begin
      for (int i = 0; i < int'(N_PORTS); i++) begin
        if (acc[i*int'(N_PORTS)+j]) begin
          out_vld_d[j]                 = 1'b1;
          out_sel_d[j*PTR_W +: PTR_W]  = PTR_W'(i);
        end
      end
    end
  end

  // Pointers move only on acceptance, one past the partner
  always_comb begin
    gptr_d = gptr_q;
    aptr_d = aptr_q;
    for (int j = 0; j < int'(N_PORTS); j++) begin
      if (out_vld_d[j])
        gptr_d[j*PTR_W +: PTR_W] =
          PTR_W'(wrap_next(int'(out_sel_d[j*PTR_W +: PTR_W]), N_PORTS));
    end
    for (int i = 0; i < int'(N_PORTS); i++) begin
      if (acc_vld[i])
        aptr_d[i*PTR_W +: PTR_W] =
          PTR_W'(wrap_next(int'(acc_idx[i*PTR_W +: PTR_W]), N_PORTS));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gptr_q    <= '0;
      aptr_q    <= '0;
      match_o   <= '0;
      xmit_o    <= '0;
      sel_o     <= '0;
      out_vld_o <= '0;
    end else begin
      gptr_q    <= gptr_d;
      aptr_q    <= aptr_d;
      match_o   <= acc;
      xmit_o    <= acc_vld;
      sel_o     <= out_sel_d;
      out_vld_o <= out_vld_d;
    end
  end
endmodule

// File: rtl/islip_sched_chk.sv
module islip_sched_chk #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned PTR_W   = $clog2(N_PORTS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_PORTS*N_PORTS-1:0] req_i,
  input logic [N_PORTS*N_PORTS-1:0] match_o,
  input logic [N_PORTS-1:0]         xmit_o,
  input logic [N_PORTS*PTR_W-1:0]   sel_o,
  input logic [N_PORTS-1:0]         out_vld_o,
  input logic [N_PORTS*PTR_W-1:0]   gptr_q,
  input logic [N_PORTS*PTR_W-1:0]   aptr_q
);
  localparam int NP = int'(N_PORTS);

  a_r8_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i) == '0) |-> (match_o == '0));

  a_r2_only_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o & ~$past(req_i)) == '0);

  for (genvar i = 0; i < NP; i++) begin : g_in
    a_r2_row_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(match_o[i*NP +: NP]));

    a_r6_aptr_past_partner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xmit_o[i] |-> match_o[i*NP + ((int'(aptr_q[i*PTR_W +: PTR_W]) + NP - 1) % NP)]);

    a_r7_aptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !xmit_o[i] |-> $stable(aptr_q[i*PTR_W +: PTR_W]));
  end

  for (genvar j = 0; j < NP; j++) begin : g_out
    logic [N_PORTS-1:0] col;
    for (genvar i = 0; i < NP; i++) begin : g_col
      assign col[i] = match_o[i*NP + j];
    end

    a_r2_col_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));

    a_r9_sel_points_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_vld_o[j] |-> col[sel_o[j*PTR_W +: PTR_W]]);

    a_r5_gptr_past_partner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_vld_o[j] |->
        (int'(gptr_q[j*PTR_W +: PTR_W]) ==
         (int'(sel_o[j*PTR_W +: PTR_W]) + 1) % NP));

    a_r7_gptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_vld_o[j] |-> $stable(gptr_q[j*PTR_W +: PTR_W]));
  end
endmodule

bind islip_sched islip_sched_chk #(.N_PORTS(N_PORTS), .PTR_W(PTR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .match_o   (match_o),
  .xmit_o    (xmit_o),
  .sel_o     (sel_o),
  .out_vld_o (out_vld_o),
  .gptr_q    (gptr_q),
  .aptr_q    (aptr_q)
);

// File: tb/islip_sched_tb.sv
module islip_sched_tb_top;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int NV = 5;
  localparam logic [63:0] FULL = {64{1'b1}};

  // Back-to-back passes from reset; expected matches hand-derived from R3-R7
  localparam logic [63:0] VEC_REQ [NV] = '{FULL, FULL, FULL, 64'h0, FULL};
  localparam logic [63:0] VEC_EXP [NV] = '{
    64'h0000_0000_0000_0001,  // 0->0
    64'h0000_0000_0000_0102,  // 0->1, 1->0
    64'h0000_0000_0001_0204,  // 0->2, 1->1, 2->0
    64'h0000_0000_0000_0000,  // idle, pointers hold
    64'h0000_0000_0102_0408   // 0->3, 1->2, 2->1, 3->0
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [63:0]     req_i = '0;
  logic [63:0]     match_o;
  logic [N-1:0]    xmit_o;
  logic [N*PW-1:0] sel_o;
  logic [N-1:0]    out_vld_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  islip_sched dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .match_o   (match_o),
    .xmit_o    (xmit_o),
    .sel_o     (sel_o),
    .out_vld_o (out_vld_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Derived per-port views of an expected matching (R9)
  task automatic check_views(input string tag, input logic [63:0] m);
    logic [N-1:0]    ex_x;
    logic [N-1:0]    ex_v;
    logic [N*PW-1:0] ex_s;
    ex_x = '0; ex_v = '0; ex_s = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (m[i*N+j]) begin
          ex_x[i] = 1'b1;
          ex_v[j] = 1'b1;
          ex_s[j*PW +: PW] = PW'(i);
        end
      end
    end
    check({tag, " R9 xmit"}, 64'(xmit_o), 64'(ex_x));
    check({tag, " R9 out_vld"}, 64'(out_vld_o), 64'(ex_v));
    check({tag, " R9 sel"}, 64'(sel_o), 64'(ex_s));
  endtask

  task automatic step(input logic [63:0] rq);
    req_i = rq;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_i  = FULL;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 reset match", match_o, 64'h0);
    check("R1 reset xmit/vld", {48'h0, xmit_o, out_vld_o}, 64'h0);
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();

    // Table: full load desynchronises pointers; idle step keeps them (R3-R8, R10)
    for (int v = 0; v < NV; v++) begin
      step(VEC_REQ[v]);
      check($sformatf("R2 R3 R4 R5 R6 R7 R8 R10 table step %0d", v), match_o, VEC_EXP[v]);
      check_views($sformatf("table step %0d", v), VEC_EXP[v]);
    end

    // R1: after reset every arbiter favours index 0 again
    do_reset();
    step(FULL);
    check("R1 first pass after reset", match_o, 64'h1);

    // R7: output 1 granted input 0 but was refused; its pointer must stay at 0
    do_reset();
    step(64'h0000_0000_0000_0003);
    check("R4 input 0 accepts output 0", match_o, 64'h1);
    step(64'h0000_0000_0000_0202);
    check("R7 refused grant keeps pointer", match_o, 64'h2);
    check_views("R7", 64'h2);

    // R5/R6 wrap: pair 7->7 moves both pointers to 0
    do_reset();
    step(64'h8000_0000_0000_0000);
    check("R5 R6 pair 7-7", match_o, 64'h8000_0000_0000_0000);
    check_views("R5 wrap", 64'h8000_0000_0000_0000);
    step(64'h8000_0000_0000_0080);
    check("R5 pointer wraps to input 0", match_o, 64'h80);

    // R2: request only on a single off-diagonal pair, unrequested pairs stay clear
    step(64'h0000_0000_0020_0000);
    check("R2 single pair 2->5", match_o, 64'h0000_0000_0020_0000);
    step(64'h0);
    check("R8 idle gives empty matching", match_o, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule